// File: doc/BRIEF.md
# System Management Interrupt Request Capture

This block turns requests for a system management interrupt into a single take strobe delivered at an instruction boundary. Requests come from two sources. The first is an asynchronous, active-low request pin, which is synchronized and then edge detected. The second is a one-cycle pulse from the interrupt-controller message port. Both sources feed one capture slot. The block also decides, at each boundary, whether the core enters the management handler, takes an NMI, or takes neither.

After a management request is taken, further requests are masked until the handler signals resume-done. One request that arrives during that time is held. It is delivered at the first boundary after resume, so a second handler entry follows the first with no instruction of the interrupted program in between. The edge detector on the pin rearms only after the synchronized line has stayed high for a set number of clocks. Requests arriving while the core is in its shutdown state are discarded.

Top module: `smi_capture`

## Requirements
- R1: The pin is active-low and asynchronous and is synchronized by two flops. A low level held for one clock is captured. The first boundary that can take the request is the third falling clock edge after the pin was driven low; a boundary one clock earlier takes nothing.
- R2: A low level held on the pin for many clocks produces exactly one request.
- R3: After a captured falling edge, the detector rearms only once the synchronized pin has been high for 4 consecutive clocks (`REARM_CLKS`). A low that follows only 3 high clocks is ignored; a low that follows 4 high clocks is captured.
- R4: `take_smi_o` is asserted only in a cycle with `boundary_i` high and `locked_i` low. A boundary during a locked sequence takes neither SMI nor NMI, and the request is kept for a later unlocked boundary.
- R5: After `take_smi_o`, no further SMI is taken until `resume_i` has been pulsed.
- R6: While masked, one request is held as pending. Any further requests while masked merge into it and are lost.
- R7: A pending request is taken at the first boundary after `resume_i`, ahead of an NMI that is requested at the same time.
- R8: If SMI and NMI are both ready at a boundary, only `take_smi_o` rises. With no SMI ready, `take_nmi_o` follows `nmi_req_i` at an unlocked boundary. Taking an NMI does not mask SMI.
- R9: Requests from either source that arrive while `shutdown_i` is high are discarded and are not taken after shutdown ends.
- R10: A `msg_req_i` pulse is captured at the next clock edge. A boundary in the following cycle takes it, under the same masking and pending rules as the pin.
- R11: Reset clears the pending request and the mask and leaves the pin detector armed. The take strobes are low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_pin_ni | input | 1 | Asynchronous management request pin, active low, falling-edge triggered |
| msg_req_i | input | 1 | One-cycle request pulse from the interrupt-controller message port |
| boundary_i | input | 1 | High in a cycle that is an instruction boundary |
| locked_i | input | 1 | High while a locked bus sequence is open |
| shutdown_i | input | 1 | High while the core is in its shutdown state |
| resume_i | input | 1 | One-cycle pulse when the management handler has returned |
| nmi_req_i | input | 1 | Level NMI request |
| take_smi_o | output | 1 | Strobe: enter the management handler at this boundary |
| take_nmi_o | output | 1 | Strobe: take the NMI at this boundary |

## Verification
The hardest case to reach is the rearm window. The pin must be dropped again exactly three or four clocks after release, and this second fall must land while the first request is already masked. Only then does the result depend on the detector alone and not on merging in the capture slot. The bench drives the pin pattern and the boundary strobe from two concurrent branches. This takes the first request in the middle of the pin pattern. It then resumes and reads the second boundary to see whether a pending request was created. Back-to-back entry against a waiting NMI is reached the same way: a message pulse is sent while masked, with the NMI request already held high.

// File: rtl/smi_capture_pkg.sv
package smi_capture_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned REARM_CLKS_DEF  = 4;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  // resets to the inactive (high) level
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/smi_edge_rearm.sv
module smi_edge_rearm #(
  parameter int unsigned REARM_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic fall_o
);
  localparam int unsigned CW = smi_capture_pkg::cnt_width(REARM_CLKS);
  localparam logic [CW-1:0] LAST = CW'(REARM_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  assign fall_o = armed_q & ~level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!level_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q) begin
      if (cnt_q == LAST) armed_q <= 1'b1;
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R2
  one_fall_per_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

  // R3
  fall_needs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> $past(level_i));
endmodule

// File: rtl/smi_arbiter.sv
module smi_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_event_i,
  input  logic boundary_i,
  input  logic locked_i,
  input  logic resume_i,
  input  logic nmi_req_i,
  output logic take_smi_o,
  output logic take_nmi_o
);
  logic req_q;
  logic mask_q;
  logic open_bnd;

  assign open_bnd   = boundary_i & ~locked_i;
  assign take_smi_o = open_bnd & req_q & ~mask_q;
  assign take_nmi_o = open_bnd & nmi_req_i & ~take_smi_o;

  // single slot: waiting request or, while masked, the pending one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      req_q <= (req_q & ~take_smi_o) | req_event_i;
      if (take_smi_o)    mask_q <= 1'b1;
      else if (resume_i) mask_q <= 1'b0;
    end
  end

  // R5
  no_reentry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_smi_o |=> !take_smi_o);

  // R7
  pending_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(resume_i) && !$past(take_smi_o) && req_q && open_bnd) |-> take_smi_o);

  // R8
  single_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_smi_o && take_nmi_o));
endmodule

// File: rtl/smi_capture.sv
module smi_capture #(
  parameter int unsigned SYNC_STAGES = smi_capture_pkg::SYNC_STAGES_DEF,
  parameter int unsigned REARM_CLKS  = smi_capture_pkg::REARM_CLKS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_pin_ni,
  input  logic msg_req_i,
  input  logic boundary_i,
  input  logic locked_i,
  input  logic shutdown_i,
  input  logic resume_i,
  input  logic nmi_req_i,
  output logic take_smi_o,
  output logic take_nmi_o
);
  logic pin_s;
  logic pin_fall;
  logic req_event;

  smi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(req_pin_ni),
    .sync_o (pin_s)
  );

  smi_edge_rearm #(.REARM_CLKS(REARM_CLKS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(pin_s),
    .fall_o (pin_fall)
  );

  // message pulse joins after the edge detector; shutdown drops both
  assign req_event = (pin_fall | msg_req_i) & ~shutdown_i;

  smi_arbiter u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_event_i(req_event),
    .boundary_i (boundary_i),
    .locked_i   (locked_i),
    .resume_i   (resume_i),
    .nmi_req_i  (nmi_req_i),
    .take_smi_o (take_smi_o),
    .take_nmi_o (take_nmi_o)
  );

  // R4
  take_at_open_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_smi_o |-> (boundary_i && !locked_i));

  // R9
  shutdown_no_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_i && msg_req_i && !take_smi_o && !$past(req_event)) |=> !$past(req_event));
endmodule

// File: tb/smi_capture_bench.sv
module smi_capture_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_pin_ni = 1'b1;
  logic msg_req_i = 1'b0;
  logic boundary_i = 1'b0;
  logic locked_i = 1'b0;
  logic shutdown_i = 1'b0;
  logic resume_i = 1'b0;
  logic nmi_req_i = 1'b0;
  logic take_smi_o, take_nmi_o;

  int total = 0;
  int bad = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  smi_capture u_smi_capture (
    .clk_i(clk), .rst_ni(rst_ni), .req_pin_ni(req_pin_ni), .msg_req_i(msg_req_i),
    .boundary_i(boundary_i), .locked_i(locked_i), .shutdown_i(shutdown_i),
    .resume_i(resume_i), .nmi_req_i(nmi_req_i),
    .take_smi_o(take_smi_o), .take_nmi_o(take_nmi_o)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bnd(input logic exp_smi, input logic exp_nmi, input string tag);
    boundary_i = 1'b1;
    #1;
    check(take_smi_o, exp_smi, {tag, " take_smi"});
    check(take_nmi_o, exp_nmi, {tag, " take_nmi"});
    @(negedge clk);
    boundary_i = 1'b0;
  endtask

  task automatic resume_pulse();
    resume_i = 1'b1;
    @(negedge clk);
    resume_i = 1'b0;
  endtask

  task automatic msg_pulse();
    msg_req_i = 1'b1;
    @(negedge clk);
    msg_req_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(take_smi_o, 1'b0, "R11 reset smi");
    check(take_nmi_o, 1'b0, "R11 reset nmi");
    bnd(1'b0, 1'b0, "R11 idle boundary");
  endtask

  task automatic t_pin_single();
    req_pin_ni = 1'b0;
    nclk(1);
    req_pin_ni = 1'b1;
    nclk(1);
    bnd(1'b0, 1'b0, "R1 too early");
    bnd(1'b1, 1'b0, "R1 captured");
    resume_pulse();
    nclk(6);
  endtask

  task automatic t_pin_hold();
    req_pin_ni = 1'b0;
    nclk(10);
    bnd(1'b1, 1'b0, "R2 held low first");
    resume_pulse();
    bnd(1'b0, 1'b0, "R2 held low no repeat");
    req_pin_ni = 1'b1;
    nclk(8);
  endtask

  task automatic t_rearm(input int high_clks, input logic exp, input string tag);
    fork
      begin
        req_pin_ni = 1'b0;
        nclk(1);
        req_pin_ni = 1'b1;
        nclk(high_clks);
        req_pin_ni = 1'b0;
        nclk(1);
        req_pin_ni = 1'b1;
      end
      begin
        nclk(3);
        bnd(1'b1, 1'b0, {tag, " first edge"});
      end
    join
    nclk(4);
    resume_pulse();
    bnd(exp, 1'b0, tag);
    if (exp) resume_pulse();
    nclk(6);
  endtask

  task automatic t_lock();
    msg_pulse();
    locked_i = 1'b1;
    bnd(1'b0, 1'b0, "R4 locked boundary");
    nclk(2);
    #1;
    check(take_smi_o, 1'b0, "R4 no boundary");
    @(negedge clk);
    locked_i = 1'b0;
    bnd(1'b1, 1'b0, "R4 unlocked boundary");
    resume_pulse();
  endtask

  task automatic t_mask_pending();
    msg_pulse();
    bnd(1'b1, 1'b0, "R5 first take");
    msg_pulse();
    nclk(1);
    msg_pulse();
    bnd(1'b0, 1'b0, "R5 masked");
    resume_pulse();
    bnd(1'b1, 1'b0, "R6 pending taken");
    resume_pulse();
    bnd(1'b0, 1'b0, "R6 extra dropped");
  endtask

  task automatic t_back_to_back();
    msg_pulse();
    bnd(1'b1, 1'b0, "R7 first take");
    msg_pulse();
    nmi_req_i = 1'b1;
    resume_pulse();
    bnd(1'b1, 1'b0, "R7 pending before nmi");
    resume_pulse();
    bnd(1'b0, 1'b1, "R7 nmi after");
    nmi_req_i = 1'b0;
  endtask

  task automatic t_priority();
    nmi_req_i = 1'b1;
    msg_pulse();
    bnd(1'b1, 1'b0, "R8 smi wins");
    resume_pulse();
    bnd(1'b0, 1'b1, "R8 nmi next");
    nmi_req_i = 1'b0;
    msg_pulse();
    bnd(1'b1, 1'b0, "R8 smi in nmi handler");
    resume_pulse();
  endtask

  task automatic t_shutdown();
    shutdown_i = 1'b1;
    msg_pulse();
    req_pin_ni = 1'b0;
    nclk(1);
    req_pin_ni = 1'b1;
    nclk(3);
    shutdown_i = 1'b0;
    bnd(1'b0, 1'b0, "R9 dropped in shutdown");
    nclk(6);
    req_pin_ni = 1'b0;
    nclk(1);
    req_pin_ni = 1'b1;
    nclk(2);
    bnd(1'b1, 1'b0, "R9 after shutdown");
    resume_pulse();
    nclk(6);
  endtask

  task automatic t_msg();
    msg_pulse();
    bnd(1'b1, 1'b0, "R10 message one clock");
    resume_pulse();
  endtask

  task automatic t_reset_mid();
    msg_pulse();
    bnd(1'b1, 1'b0, "R11 pre reset take");
    msg_pulse();
    rst_ni = 1'b0;
    nclk(2);
    rst_ni = 1'b1;
    nclk(1);
    bnd(1'b0, 1'b0, "R11 pending cleared");
    msg_pulse();
    bnd(1'b1, 1'b0, "R11 mask cleared");
    resume_pulse();
    rst_ni = 1'b0;
    nclk(2);
    rst_ni = 1'b1;
    req_pin_ni = 1'b0;
    nclk(1);
    req_pin_ni = 1'b1;
    nclk(2);
    bnd(1'b1, 1'b0, "R11 detector armed");
    resume_pulse();
  endtask

  initial begin
    nclk(4);
    rst_ni = 1'b1;
    nclk(1);
    t_reset();
    t_pin_single();
    t_pin_hold();
    t_rearm(3, 1'b0, "R3 three high clocks");
    t_rearm(4, 1'b1, "R3 four high clocks");
    t_lock();
    t_mask_pending();
    t_back_to_back();
    t_priority();
    t_shutdown();
    t_msg();
    t_reset_mid();
    nclk(2);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule